// File: doc/BRIEF.md
# Staggered Channel Switching Sequencer

This block sits between the latched per-channel on/off bits of a multi-channel LED sink driver and the channel drive stages. It combines each latched bit with a global active-low output enable and turns the result into one drive signal per channel. Channel edges are spread out in time so that the supply does not see every channel switch in the same instant. Channel 0 follows the command at once. Each higher channel follows it a fixed number of clock cycles later, and that number grows with the channel index. The spread applies to turn-on and turn-off alike.

The output enable can be toggled as a global brightness PWM. The command is therefore sampled on every clock edge, and every sampled value travels down each channel's delay path, so no pulse is lost. A thermal force-off input blanks all drives at once, without any spread, and does not disturb the queued commands. A busy output is high while any channel still has a switching event queued or has not yet reached its commanded level. The delay unit `STEP_CYCLES` is a parameter in clock cycles. For example, with a 50 MHz clock, a value of 1 gives a 20 ns step.

Top module: `stagger_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no command yet sampled, every drive bit is 0 and busy is 0.
- R2: The command for a channel is `chan_on[i] & ~oe_n`. On the first clock edge that samples a command, drive bit 0 takes the value `cmd[0] & ~therm_off`.
- R3: Drive bit i, after clock edge k, equals the channel-i command sampled at edge k - i*STEP_CYCLES. This holds for rising and falling transitions alike, and the thermal gate still applies.
- R4: While `oe_n` is 1, every command bit is 0. After `oe_n` has been held high for (CHANNELS-1)*STEP_CYCLES+1 edges, every drive bit is 0, whatever `chan_on` holds.
- R5: A command value held for a single clock edge, such as a one-cycle enable pulse, appears on every channel for exactly one cycle at that channel's delay.
- R6: On any edge that samples `therm_off` = 1, every drive bit becomes 0 with no stagger. When the edge samples `therm_off` = 0 again, each channel shows its delayed command from R3.
- R7: If a channel's command changes several times within its delay window, the channel ends in the last commanded state once the command has been held for (CHANNELS-1)*STEP_CYCLES+1 edges. Busy is 0 at that point.
- R8: `busy` is 1 exactly when, for some channel, either condition holds. The first is that a command sampled in its last i*STEP_CYCLES edges differs from its present command. The second is that its drive differs from its present command gated by `therm_off`. When busy is 0, the next edge leaves every drive bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all queued commands and drives |
| chan_on | input | CHANNELS | Latched per-channel on/off bits, bit i for channel i |
| oe_n | input | 1 | Global output enable, active low; 1 turns every command off |
| therm_off | input | 1 | Thermal force-off; 1 blanks every drive at once |
| drive | output | CHANNELS | Staggered channel drive signals, bit i for channel i |
| busy | output | 1 | 1 while any staggered transition is pending |

## Verification
The bench builds the block with 16 channels and a 3-cycle step. This gives a 45-cycle span, long enough for several overlapping transitions to be in flight on different channels at once. It also keeps directed settle phases short. A step above 1 places every channel's edge away from its neighbours' edges, so an off-by-one in a delay path shows up as a visible mismatch. A random per-cycle enable pulse then exercises the single-cycle-pulse and latest-command cases on every channel.

// File: rtl/stagger_pkg.sv
package stagger_pkg;

  // Number of clock cycles channel idx lags channel 0.
  function automatic int unsigned chan_delay(input int unsigned idx,
                                             input int unsigned step);
    return idx * step;
  endfunction

  // Cycles from the first channel's edge to the last channel's edge.
  function automatic int unsigned full_span(input int unsigned chans,
                                            input int unsigned step);
    return (chans - 1) * step;
  endfunction

endpackage

// File: rtl/stagger_cmd.sv
// Forms the per-channel command from the latched bits and the global enable.
module stagger_cmd #(
  parameter int unsigned CHANNELS = 16
) (
  input  logic [CHANNELS-1:0] chan_on,
  input  logic                oe_n,
  output logic [CHANNELS-1:0] cmd
);
  always_comb begin
    cmd = oe_n ? '0 : chan_on;
  end
endmodule

// File: rtl/stagger_tap.sv
// Shift chain of LEN cycles for one channel, plus a flag that is set when any
// queued sample differs from the present command.
module stagger_tap #(
  parameter int unsigned LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic tap,
  output logic diff
);
  logic [LEN-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else begin
      sr[0] <= din;
      for (int k = 1; k < int'(LEN); k++) begin
        sr[k] <= sr[k-1];
      end
    end
  end

  assign tap  = sr[LEN-1];
  assign diff = |(sr ^ {LEN{din}});
endmodule

// File: rtl/stagger_drive.sv
// Output register with the thermal gate, and the pending-transition flag.
module stagger_drive #(
  parameter int unsigned CHANNELS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] tap_out,
  input  logic [CHANNELS-1:0] cmd,
  input  logic [CHANNELS-1:0] chain_diff,
  input  logic                therm_off,
  output logic [CHANNELS-1:0] drive,
  output logic                busy
);
  logic [CHANNELS-1:0] settled_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive <= '0;
    end else begin
      drive <= tap_out & ~{CHANNELS{therm_off}};
    end
  end

  assign settled_lvl = cmd & ~{CHANNELS{therm_off}};
  assign busy        = (|chain_diff) | (|(drive ^ settled_lvl));
endmodule

// File: rtl/stagger_seq.sv
module stagger_seq #(
  parameter int unsigned CHANNELS    = 16,
  parameter int unsigned STEP_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] chan_on,
  input  logic                oe_n,
  input  logic                therm_off,
  output logic [CHANNELS-1:0] drive,
  output logic                busy
);
  import stagger_pkg::*;

  localparam int unsigned SPAN = full_span(CHANNELS, STEP_CYCLES);

  // Named internal events, brought out for the checker.
  logic [CHANNELS-1:0] cmd;
  logic [CHANNELS-1:0] tap_out;
  logic [CHANNELS-1:0] chain_diff;

  stagger_cmd #(.CHANNELS(CHANNELS)) u_cmd (
    .chan_on (chan_on),
    .oe_n    (oe_n),
    .cmd     (cmd)
  );

  for (genvar i = 0; i < int'(CHANNELS); i++) begin : g_chan
    localparam int unsigned LEN = chan_delay(i, STEP_CYCLES);
    if (LEN == 0) begin : g_direct
      assign tap_out[i]    = cmd[i];
      assign chain_diff[i] = 1'b0;
    end else begin : g_chain
      stagger_tap #(.LEN(LEN)) u_tap (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cmd[i]),
        .tap   (tap_out[i]),
        .diff  (chain_diff[i])
      );
    end
  end

  stagger_drive #(.CHANNELS(CHANNELS)) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .tap_out    (tap_out),
    .cmd        (cmd),
    .chain_diff (chain_diff),
    .therm_off  (therm_off),
    .drive      (drive),
    .busy       (busy)
  );

  initial begin
    assert (SPAN < 65536) else $error("stagger span too large");
  end
endmodule

// File: rtl/stagger_seq_chk.sv
module stagger_seq_chk #(
  parameter int unsigned CHANNELS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CHANNELS-1:0] chan_on,
  input logic                oe_n,
  input logic                therm_off,
  input logic [CHANNELS-1:0] drive,
  input logic                busy,
  input logic [CHANNELS-1:0] tap_out
);
  // R6
  therm_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    therm_off |=> (drive == '0));

  // R2
  chan0_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drive[0] == $past(chan_on[0] & ~oe_n & ~therm_off)));

  // R3
  tap_to_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drive == $past(tap_out & ~{CHANNELS{therm_off}})));

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(drive));

  // R4
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> (drive[0] == 1'b0));
endmodule

bind stagger_seq stagger_seq_chk #(.CHANNELS(CHANNELS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chan_on   (chan_on),
  .oe_n      (oe_n),
  .therm_off (therm_off),
  .drive     (drive),
  .busy      (busy),
  .tap_out   (tap_out)
);

// File: tb/stagger_seq_tb.sv
module stagger_seq_tb;
  localparam int N = 16;
  localparam int STEP = 3;
  localparam int D = N * STEP;
  localparam int SPAN = (N - 1) * STEP;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] chan_on = '0;
  logic         oe_n = 1'b1;
  logic         therm_off = 1'b0;
  logic [N-1:0] drive;
  logic         busy;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Bench model state: command sampled at each edge, newest at index 0.
  logic [N-1:0] hist [0:D];
  logic         therm_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  stagger_seq #(.CHANNELS(N), .STEP_CYCLES(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_on(chan_on), .oe_n(oe_n),
    .therm_off(therm_off), .drive(drive), .busy(busy)
  );

  function automatic logic [N-1:0] cmd_of(input logic [N-1:0] on, input logic oe);
    return oe ? '0 : on;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j <= D; j++) hist[j] <= '0;
      therm_last <= 1'b0;
    end else begin
      for (int j = D; j > 0; j--) hist[j] <= hist[j-1];
      hist[0] <= cmd_of(chan_on, oe_n);
      therm_last <= therm_off;
    end
  end

  function automatic logic [N-1:0] model_drive();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = hist[i*STEP][i] & ~therm_last;
    return r;
  endfunction

  function automatic logic model_busy();
    logic [N-1:0] c;
    logic [N-1:0] md;
    logic b;
    c = cmd_of(chan_on, oe_n);
    md = model_drive();
    b = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < i*STEP; j++) if (hist[j][i] != c[i]) b = 1'b1;
      if (md[i] != (c[i] & ~therm_off)) b = 1'b1;
    end
    return b;
  endfunction

  task automatic check_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: check outputs of the last edge, apply new inputs, check busy.
  task automatic cyc(input logic [N-1:0] on, input logic oe, input logic th, input string req);
    logic [N-1:0] md;
    @(negedge clk);
    md = model_drive();
    check_bit("R2", drive[0], md[0]);
    check_vec(req, drive, md);
    chan_on = on;
    oe_n = oe;
    therm_off = th;
    #1;
    check_bit("R8", busy, model_busy());
  endtask

  task automatic hold(input logic [N-1:0] on, input logic oe, input int n, input string req);
    for (int k = 0; k < n; k++) cyc(on, oe, 1'b0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    check_vec("R1", drive, '0);
    check_bit("R1", busy, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_vec("R1", drive, '0);
    check_bit("R1", busy, 1'b0);

    // Directed: all on, then all off, with stagger on both edges (R3).
    hold('1, 1'b0, SPAN + 3, "R3");
    check_vec("R3", drive, '1);
    hold('0, 1'b0, SPAN + 3, "R3");
    check_vec("R3", drive, '0);
    hold(16'hA5C3, 1'b0, SPAN + 3, "R3");

    // Random on/off bits with a random per-cycle enable PWM (R5).
    for (int k = 0; k < 300; k++)
      cyc(N'($urandom), 1'($urandom), 1'b0, "R5");
    // Single-cycle enable pulse on a quiet field.
    hold('1, 1'b1, SPAN + 2, "R5");
    cyc('1, 1'b0, 1'b0, "R5");
    hold('1, 1'b1, SPAN + 3, "R5");

    // Enable held high: everything off regardless of bits (R4).
    hold('1, 1'b0, SPAN + 2, "R4");
    for (int k = 0; k < SPAN + 2; k++) cyc(N'($urandom), 1'b1, 1'b0, "R4");
    @(negedge clk);
    check_vec("R4", drive, '0);

    // Thermal force-off: immediate blanking, resume on release (R6).
    hold('1, 1'b0, SPAN + 2, "R6");
    cyc('1, 1'b0, 1'b1, "R6");
    @(negedge clk);
    check_vec("R6", drive, '0);
    for (int k = 0; k < 200; k++)
      cyc(N'($urandom), 1'($urandom), ($urandom % 5) == 0, "R6");

    // Rapid command changes, then hold: latest wins (R7).
    for (int k = 0; k < 10; k++) cyc(N'($urandom), 1'b0, 1'b0, "R7");
    pat = 16'h3C69;
    hold(pat, 1'b0, SPAN + 1, "R7");
    @(negedge clk);
    check_vec("R7", drive, pat);
    check_bit("R7", busy, 1'b0);

    // Long mixed random run, busy checked every cycle (R8).
    for (int k = 0; k < 400; k++)
      cyc(($urandom % 4 == 0) ? N'($urandom) : chan_on, ($urandom % 6) == 0,
          ($urandom % 23) == 0, "R8");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule